// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Flags

This block is a small memory-mapped peripheral holding two 16-bit down counters and the interrupt bookkeeping around them. The host reaches it over a plain byte-wide register bus: an address, write data with a write strobe, and a read strobe with read data. Timer 1 reloads itself from a 16-bit latch. It can raise its flag once per load or on every period. Timer 2 is a one-shot counter that wraps with no reload. A flag register records timer expiries and an external shift-complete event. An enable register, written with a set/clear protocol, decides which flags count as pending. One interrupt line is driven from the enabled flags of timer 1 and the shift source only.

A `tick` input advances both counters by one count per cycle in which it is high. There is no prescaler. The register bus has no handshake: a write takes effect at the clock edge where `bus_we` is high. Read data follows `bus_addr` combinationally in the same cycle. Any side effect of a read happens at the edge where `bus_re` is high.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset, both counters, all latches, the auxiliary register, the flags and the enables are zero, and `irq` is low. Reading the enable register (address 8) returns 0x80.
- R2: A write to address 1 (timer 1 count high) loads {wdata, latch low} into timer 1, sets latch high to wdata, re-arms timer 1 and clears flag bit 6. A write to address 0 or 2 sets only latch low. A write to address 3 sets only latch high. Addresses 2 and 3 read back the latch.
- R3: Each cycle with `tick` high, timer 1 decrements by one. From 0 it goes to 0xFFFF, and from 0xFFFF it reloads the 16-bit latch, so one free-running period is latch+2 ticks. With `tick` low the count holds.
- R4: When auxiliary bits 7..6 (address 6) are not 01, timer 1 sets flag bit 6 only on its first 0-to-0xFFFF step after a load.
- R5: When auxiliary bits 7..6 are 01, timer 1 sets flag bit 6 on every 0-to-0xFFFF step.
- R6: A write to address 4 sets the timer 2 latch low byte. A write to address 5 loads {wdata, that byte} into timer 2, re-arms it and clears flag bit 5. Timer 2 decrements on each tick, wraps from 0 to 0xFFFF without reloading, and sets flag bit 5 once per load.
- R7: Addresses 0/1 and 4/5 return the live low and high count bytes. A read strobe on address 0 clears flag bit 6, and one on address 4 clears flag bit 5.
- R8: A write to the enable register with bit 7 high sets every enable in bits 6..0 written as 1. With bit 7 low it clears every enable written as 1. Enables written as 0 keep their value.
- R9: A pulse on `shift_done` sets flag bit 2. Writing 1s to address 7 clears those flag bits among 6..0. A flag that is set and cleared in the same cycle ends up set.
- R10: Reading address 7 returns flag bits 6..0, with bit 7 high when any flag is both set and enabled. Reading address 8 returns the enables with bit 7 forced high.
- R11: `irq` is high exactly when flag and enable are both set for bit 6 or for bit 2. Timer 2's flag never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for both timers |
| shift_done | input | 1 | Pulse that sets the shift flag (bit 2) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (for read side effects) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit bus and a 4-bit address. Small latch values keep a full timer 1 period within a few ticks, so the latch+2 spacing of continuous flags and the single flag of one-shot mode both show up over several periods. Loading timer 2 with a small value brings its wrap through 0xFFFF, without reload, within reach. With the 8-bit bus, bit 7 of the enable write is the set/clear selector and bit 7 of the flag read is the summary bit.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int ADR_T1_CNT_LO = 0;
  localparam int ADR_T1_CNT_HI = 1;
  localparam int ADR_T1_LAT_LO = 2;
  localparam int ADR_T1_LAT_HI = 3;
  localparam int ADR_T2_CNT_LO = 4;
  localparam int ADR_T2_CNT_HI = 5;
  localparam int ADR_AUX       = 6;
  localparam int ADR_FLAGS     = 7;
  localparam int ADR_ENABLES   = 8;

  localparam int FLG_T1 = 6;
  localparam int FLG_T2 = 5;
  localparam int FLG_SR = 2;

  localparam logic [1:0] T1_MODE_CONT = 2'b01;
endpackage

// File: rtl/dtim_counter.sv
module dtim_counter #(
  parameter int CW     = 16,
  parameter bit RELOAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          cont_mode,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic          armed_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] next_cnt;

  generate
    if (RELOAD) begin : g_reload
      // After passing through all-ones, fetch the latch
      assign next_cnt = (count_q == '1) ? reload_val : count_q - 1'b1;
    end else begin : g_wrap
      logic unused_reload;
      assign unused_reload = ^reload_val;
      assign next_cnt = count_q - 1'b1;
    end
  endgenerate

  // Expiry: the step from zero to all-ones, when armed or free-running
  assign expire = tick && !load && (count_q == '0) && (armed_q || cont_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      armed_q <= 1'b1;
    end else if (tick) begin
      count_q <= next_cnt;
      if (expire) armed_q <= 1'b0;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/dtim_irq_ctrl.sv
module dtim_irq_ctrl #(
  parameter int            FW       = 7,
  parameter logic [FW-1:0] IRQ_MASK = 7'h44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic [FW-1:0] clr_vec,
  input  logic          en_we,
  input  logic [FW:0]   en_wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] enables,
  output logic          any_pending,
  output logic          irq
);
  logic [FW-1:0] flags_q;
  logic [FW-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      // a set arriving with a clear wins
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (en_we) begin
        if (en_wdata[FW]) en_q <= en_q | en_wdata[FW-1:0];
        else              en_q <= en_q & ~en_wdata[FW-1:0];
      end
    end
  end

  assign flags       = flags_q;
  assign enables     = en_q;
  assign any_pending = |(flags_q & en_q);
  assign irq         = |(flags_q & en_q & IRQ_MASK);
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          shift_done,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import dtim_pkg::*;

  localparam int HW = CW - DW;
  localparam int FW = DW - 1;
  localparam logic [FW-1:0] IRQ_MASK = FW'((1 << FLG_T1) | (1 << FLG_SR));

  logic [DW-1:0] t1_lat_lo, t1_lat_hi, t2_lat_lo, aux_q;
  logic [CW-1:0] t1_count, t2_count;
  logic          t1_exp, t2_exp, t1_load, t2_load;
  logic [FW-1:0] flag_q, en_q, set_vec, clr_vec;
  logic          any_pending;

  function automatic logic hit(input logic [AW-1:0] a, input int ref_adr);
    return a == AW'(ref_adr);
  endfunction

  assign t1_load = bus_we && hit(bus_addr, ADR_T1_CNT_HI);
  assign t2_load = bus_we && hit(bus_addr, ADR_T2_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_lat_lo <= '0;
      t1_lat_hi <= '0;
      t2_lat_lo <= '0;
      aux_q     <= '0;
    end else if (bus_we) begin
      if (hit(bus_addr, ADR_T1_CNT_LO) || hit(bus_addr, ADR_T1_LAT_LO)) t1_lat_lo <= bus_wdata;
      if (hit(bus_addr, ADR_T1_CNT_HI) || hit(bus_addr, ADR_T1_LAT_HI)) t1_lat_hi <= bus_wdata;
      if (hit(bus_addr, ADR_T2_CNT_LO)) t2_lat_lo <= bus_wdata;
      if (hit(bus_addr, ADR_AUX))       aux_q     <= bus_wdata;
    end
  end

  dtim_counter #(.CW(CW), .RELOAD(1'b1)) u_t1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (t1_load),
    .load_val   ({bus_wdata[HW-1:0], t1_lat_lo}),
    .reload_val ({t1_lat_hi[HW-1:0], t1_lat_lo}),
    .cont_mode  (aux_q[DW-1:DW-2] == T1_MODE_CONT),
    .count      (t1_count),
    .expire     (t1_exp)
  );

  dtim_counter #(.CW(CW), .RELOAD(1'b0)) u_t2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (t2_load),
    .load_val   ({bus_wdata[HW-1:0], t2_lat_lo}),
    .reload_val ({t1_lat_hi[HW-1:0], t1_lat_lo}),
    .cont_mode  (1'b0),
    .count      (t2_count),
    .expire     (t2_exp)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[FLG_T1] = t1_exp;
    set_vec[FLG_T2] = t2_exp;
    set_vec[FLG_SR] = shift_done;
    clr_vec = (bus_we && hit(bus_addr, ADR_FLAGS)) ? bus_wdata[FW-1:0] : '0;
    if (t1_load || (bus_re && hit(bus_addr, ADR_T1_CNT_LO))) clr_vec[FLG_T1] = 1'b1;
    if (t2_load || (bus_re && hit(bus_addr, ADR_T2_CNT_LO))) clr_vec[FLG_T2] = 1'b1;
  end

  dtim_irq_ctrl #(.FW(FW), .IRQ_MASK(IRQ_MASK)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec),
    .en_we       (bus_we && hit(bus_addr, ADR_ENABLES)),
    .en_wdata    (bus_wdata),
    .flags       (flag_q),
    .enables     (en_q),
    .any_pending (any_pending),
    .irq         (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      ADR_T1_CNT_LO: bus_rdata = t1_count[DW-1:0];
      ADR_T1_CNT_HI: bus_rdata = DW'(t1_count[CW-1:DW]);
      ADR_T1_LAT_LO: bus_rdata = t1_lat_lo;
      ADR_T1_LAT_HI: bus_rdata = t1_lat_hi;
      ADR_T2_CNT_LO: bus_rdata = t2_count[DW-1:0];
      ADR_T2_CNT_HI: bus_rdata = DW'(t2_count[CW-1:DW]);
      ADR_AUX:       bus_rdata = aux_q;
      ADR_FLAGS:     bus_rdata = {any_pending, flag_q};
      ADR_ENABLES:   bus_rdata = {1'b1, en_q};
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtim_checker.sv
module dtim_checker #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic [CW-1:0] t1_count,
  input logic [DW-1:0] t1_lat_lo,
  input logic [DW-1:0] t1_lat_hi,
  input logic [DW-2:0] flag_q,
  input logic [DW-2:0] en_q,
  input logic          irq
);
  import dtim_pkg::*;

  logic ld1, en_wr;
  assign ld1   = bus_we && (bus_addr == AW'(ADR_T1_CNT_HI));
  assign en_wr = bus_we && (bus_addr == AW'(ADR_ENABLES));

  assert_t1_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld1 && t1_count == '0) |=> (t1_count == '1));

  assert_t1_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld1 && t1_count == '1) |=> (t1_count == $past({t1_lat_hi, t1_lat_lo})));

  assert_t1_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld1) |=> $stable(t1_count));

  assert_t1_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> (t1_count == {$past(bus_wdata), $past(t1_lat_lo)}) && !flag_q[FLG_T1]);

  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && bus_wdata[DW-1]) |=> ((en_q & $past(bus_wdata[DW-2:0])) == $past(bus_wdata[DW-2:0])));

  assert_en_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !bus_wdata[DW-1]) |=> ((en_q & $past(bus_wdata[DW-2:0])) == '0));

  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(flag_q[FLG_T1] && en_q[FLG_T1]) && !(flag_q[FLG_SR] && en_q[FLG_SR])) |-> !irq);
endmodule

bind dual_timer_irq dtim_checker #(.AW(AW), .DW(DW), .CW(CW)) u_dtim_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .t1_count  (t1_count),
  .t1_lat_lo (t1_lat_lo),
  .t1_lat_hi (t1_lat_hi),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .irq       (irq)
);

// File: tb/dual_timer_irq_tb_top.sv
`timescale 1ns/1ps
module dual_timer_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       shift_done = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_timer_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shift_done(shift_done),
    .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_re(re),
    .bus_rdata(rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_t1, m_t2, m_l1lo, m_l1hi, m_l2lo, m_ifr, m_ier, m_aux;
  bit m_arm1, m_arm2;
  bit ld1, ld2, e1, e2;
  int clr, setv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t1 = 0; m_t2 = 0; m_l1lo = 0; m_l1hi = 0; m_l2lo = 0;
      m_ifr = 0; m_ier = 0; m_aux = 0; m_arm1 = 0; m_arm2 = 0;
    end else begin
      ld1 = we && addr == 1;
      ld2 = we && addr == 5;
      e1 = tick && !ld1 && m_t1 == 0 && (m_arm1 || ((m_aux >> 6) & 3) == 1);
      e2 = tick && !ld2 && m_t2 == 0 && m_arm2;
      clr = (we && addr == 7) ? (wdata & 8'h7F) : 0;
      if (ld1 || (re && addr == 0)) clr = clr | 8'h40;
      if (ld2 || (re && addr == 4)) clr = clr | 8'h20;
      setv = (e1 ? 8'h40 : 0) | (e2 ? 8'h20 : 0) | (shift_done ? 8'h04 : 0);
      m_ifr = ((m_ifr & ~clr) | setv) & 8'h7F;
      if (ld1) begin m_t1 = wdata * 256 + m_l1lo; m_arm1 = 1; end
      else if (tick) begin
        m_t1 = (m_t1 == 65535) ? (m_l1hi * 256 + m_l1lo) : ((m_t1 + 65535) % 65536);
        if (e1) m_arm1 = 0;
      end
      if (ld2) begin m_t2 = wdata * 256 + m_l2lo; m_arm2 = 1; end
      else if (tick) begin
        m_t2 = (m_t2 + 65535) % 65536;
        if (e2) m_arm2 = 0;
      end
      if (we) begin
        if (addr == 0 || addr == 2) m_l1lo = wdata;
        if (addr == 1 || addr == 3) m_l1hi = wdata;
        if (addr == 4) m_l2lo = wdata;
        if (addr == 6) m_aux = wdata;
        if (addr == 8) m_ier = wdata[7] ? (m_ier | (wdata & 8'h7F)) : (m_ier & ~wdata & 8'h7F);
      end
    end
  end

  function automatic int m_read(input int a);
    case (a)
      0: return m_t1 % 256;
      1: return m_t1 / 256;
      2: return m_l1lo;
      3: return m_l1hi;
      4: return m_t2 % 256;
      5: return m_t2 / 256;
      6: return m_aux;
      7: return m_ifr | (((m_ifr & m_ier) != 0) ? 8'h80 : 0);
      8: return m_ier | 8'h80;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_ifr & m_ier & 8'h44) != 0;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison of the interrupt line (R11)
  always @(negedge clk) begin
    if (rst_n && !done) check("R11 irq per cycle", int'(irq), int'(m_irq()));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // read against the model; also against an explicit value when exp >= 0
  task automatic rd(input string tag, input int a, input int exp);
    @(negedge clk);
    addr = 4'(a); re = 1'b1;
    #1;
    check({tag, " model"}, int'(rdata), m_read(a));
    if (exp >= 0) check(tag, int'(rdata), exp);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic tick_one();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // tick n times one at a time; record at which ticks irq rises, clear it each time
  int rises[$];
  task automatic tick_watch(input int n);
    rises.delete();
    for (int i = 1; i <= n; i++) begin
      tick_one();
      if (irq) begin
        rises.push_back(i);
        wr(7, 8'h40);
      end
    end
  endtask

  int v0, v1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", int'(irq), 0);
    for (int a = 0; a < 8; a++) rd("R1 reset read", a, 0);
    rd("R1 enables read", 8, 8'h80);

    // R8 set/clear protocol of the enables
    wr(8, 8'hC4);
    rd("R8 set bits 6,2", 8, 8'hC4);
    wr(8, 8'h04);
    rd("R8 clear bit 2", 8, 8'hC0);
    wr(8, 8'h00);
    rd("R8 zero write no effect", 8, 8'hC0);
    wr(8, 8'h80);
    rd("R8 set with no bits no effect", 8, 8'hC0);

    // R2 latch-only writes do not load
    wr(2, 8'h05);
    wr(3, 8'h00);
    rd("R2 latch low readback", 2, 8'h05);
    rd("R2 latch high readback", 3, 8'h00);

    // R5 continuous mode: flag every latch+2 = 7 ticks
    wr(6, 8'h40);
    wr(1, 8'h00);
    rd("R2 load low byte", 0, 8'h05);
    rd("R2 load high byte", 1, 8'h00);
    tick_watch(22);
    check("R5 continuous flag count", rises.size(), 3);
    if (rises.size() == 3) begin
      check("R5 first flag tick", rises[0], 6);
      check("R3 period latch+2 a", rises[1] - rises[0], 7);
      check("R3 period latch+2 b", rises[2] - rises[1], 7);
    end

    // R4 one-shot mode: single flag after load
    wr(6, 8'h00);
    wr(1, 8'h00);
    rd("R2 load clears flag", 7, 8'h00);
    tick_watch(22);
    check("R4 one-shot flag count", rises.size(), 1);
    if (rises.size() == 1) check("R4 one-shot flag tick", rises[0], 6);

    // R3 hold without tick, and the 0 -> FFFF step
    wr(2, 8'h00);
    wr(1, 8'h00);
    rd("R3 hold a", 0, 8'h00);
    repeat (3) @(negedge clk);
    rd("R3 hold b", 0, 8'h00);
    tick_one();
    rd("R3 wrap low", 0, 8'hFF);
    rd("R3 wrap high", 1, 8'hFF);
    tick_one();
    rd("R3 reload from latch", 1, 8'h00);
    wr(7, 8'h7F);
    wr(8, 8'h7F);

    // R6 / R11 / R10 timer 2
    wr(8, 8'hA0);
    wr(4, 8'h03);
    wr(5, 8'h00);
    rd("R6 load", 4, 8'h03);
    run_ticks(4);
    check("R11 t2 flag gives no irq", int'(irq), 0);
    rd("R10 flags with summary bit", 7, 8'hA0);
    rd("R7 t2 live low", 4, 8'hFF);
    rd("R7 t2 read cleared flag", 7, 8'h00);
    tick_one();
    rd("R6 no reload high", 5, 8'hFF);
    rd("R6 no reload low", 4, 8'hFE);
    rd("R6 flag once per load", 7, 8'h00);

    // R7 read of timer 1 low clears its flag
    wr(8, 8'h7F);
    wr(2, 8'h01);
    wr(1, 8'h00);
    run_ticks(2);
    rd("R7 t1 flag before read", 7, 8'h40);
    rd("R7 t1 live low", 0, 8'hFF);
    rd("R7 t1 flag cleared", 7, 8'h00);

    // R9 / R11 shift source
    wr(8, 8'h84);
    @(negedge clk); shift_done = 1'b1;
    @(negedge clk); shift_done = 1'b0;
    check("R11 shift irq", int'(irq), 1);
    rd("R10 shift flag pending", 7, 8'h84);
    wr(8, 8'h04);
    check("R11 disabled shift no irq", int'(irq), 0);
    rd("R10 summary drops", 7, 8'h04);
    wr(7, 8'h04);
    rd("R9 write-one clears", 7, 8'h00);
    @(negedge clk);
    addr = 4'd7; wdata = 8'h04; we = 1'b1; shift_done = 1'b1;
    @(negedge clk);
    we = 1'b0; shift_done = 1'b0;
    rd("R9 set beats clear", 7, 8'h04);
    wr(7, 8'h20);
    rd("R9 zero bits untouched", 7, 8'h04);

    v0 = n_checks; v1 = n_fail;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule